// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This block sits in the decode stage of a two-wide in-order pipeline. Each cycle it is shown two decoded instructions: slot 0 holds the older one and slot 1 the younger. Each instruction has a class bit (integer or floating-point), up to `NSRC` source register numbers with per-source use flags, and an optional destination register. The block keeps a busy bit for every register. From those bits and the relationship between the two slots it decides whether none, one or both instructions leave decode this cycle.

The result has to match what a machine issuing one instruction per clock would do. The younger instruction therefore issues only beside an older one that is also issuing. It must be of the other class, must not read the older one's destination and must not write that same register. The block reports the issue decision, a 0/1/2 count and the scoreboard set requests. It takes writeback notices that free registers. The decoder presents loads, stores and branches as integer-class, including loads and stores that move floating-point data. Refilling the slots after a partial issue is the fetch side's job: slot 1 moves into slot 0 and a new instruction fills slot 1.

Top module: `dual_issue_pair`

## Requirements
- R1: `issue_cnt` is 0, 1 or 2 and equals the number of asserted issue outputs. An invalid slot never issues.
- R2: `issue1` is asserted only in a cycle in which `issue0` is asserted.
- R3: A pair issues only when the two class bits differ (0 = integer, 1 = floating-point). With equal classes, at most slot 0 issues.
- R4: An instruction does not issue while any source it uses, or the destination it writes, has its busy bit set.
- R5: If slot 1 uses a source equal to slot 0's destination (slot 0 writing one), only slot 0 issues.
- R6: If both slots write the same destination register, only slot 0 issues.
- R7: Each issuing instruction that writes a register raises its `set_en` bit (bit 0 for slot 0, bit 1 for slot 1) with that register on the matching `set_reg` field (low field slot 0) in the same cycle. The register's bit in `busy_mask` is 1 from the next cycle.
- R8: A `wb_valid` notice clears the named register's busy bit from the next cycle. When a notice and an issue name the same register in one cycle, the bit ends up set.
- R9: Reset clears every busy bit.
- R10: Slot 1 writing a register that slot 0 only reads does not prevent the pair from issuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_cls | input | 1 | Slot 0 class, 0 integer, 1 floating-point |
| s0_src | input | NSRC*REG_W | Slot 0 source registers, source i at bits i*REG_W |
| s0_src_use | input | NSRC | Slot 0 per-source use flags |
| s0_has_dst | input | 1 | Slot 0 writes a register |
| s0_dst | input | REG_W | Slot 0 destination register |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_cls | input | 1 | Slot 1 class |
| s1_src | input | NSRC*REG_W | Slot 1 source registers |
| s1_src_use | input | NSRC | Slot 1 per-source use flags |
| s1_has_dst | input | 1 | Slot 1 writes a register |
| s1_dst | input | REG_W | Slot 1 destination register |
| wb_valid | input | WB_PORTS | Writeback notice per port |
| wb_reg | input | WB_PORTS*REG_W | Register freed per port |
| issue0 | output | 1 | Slot 0 issues |
| issue1 | output | 1 | Slot 1 issues |
| issue_cnt | output | 2 | Number issued this cycle |
| set_en | output | 2 | Busy set request per slot |
| set_reg | output | 2*REG_W | Register to mark busy per slot |
| busy_mask | output | 2**REG_W | Current busy bits |

## Verification
The bench aims at pairs that differ from serial issue in one detail only. Examples are a floating-point load (integer-class) feeding a floating-point add in the same pair, two writes to one register, and a younger write to a register the older one only reads. A design that missed a read or double-write check would let the younger instruction through and corrupt ordering. A design that over-checked write-after-read would stall a legal pair. Multi-cycle floating-point latencies keep destinations busy across many cycles, so a scoreboard that cleared early, missed a port, or let a same-cycle writeback beat the new set would show up as a wrong `busy_mask` or a premature issue.

// File: rtl/dip_pkg.sv
package dip_pkg;
   typedef enum logic {
      CLS_INT = 1'b0,
      CLS_FP  = 1'b1
   } iclass_e;

   localparam int SLOTS = 2;
endpackage

// File: rtl/dip_scoreboard.sv
module dip_scoreboard #(
   parameter int REG_W    = 6,
   parameter int WB_PORTS = 2,
   localparam int NREGS   = 1 << REG_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                set_en,
   input  logic [2*REG_W-1:0]        set_reg,
   input  logic [WB_PORTS-1:0]       wb_valid,
   input  logic [WB_PORTS*REG_W-1:0] wb_reg,
   output logic [NREGS-1:0]          busy
);
   logic [NREGS-1:0] busy_d;

   // Clears first, sets afterwards: a new owner wins over a writeback
   always_comb begin
      busy_d = busy;
      for (int p = 0; p < WB_PORTS; p++) begin
         if (wb_valid[p]) busy_d[wb_reg[p*REG_W +: REG_W]] = 1'b0;
      end
      for (int s = 0; s < 2; s++) begin
         if (set_en[s]) busy_d[set_reg[s*REG_W +: REG_W]] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy <= '0;
      else        busy <= busy_d;
   end
endmodule

// File: rtl/dip_slot_hazard.sv
module dip_slot_hazard #(
   parameter int REG_W  = 6,
   parameter int NSRC   = 2,
   localparam int NREGS = 1 << REG_W
) (
   input  logic [NREGS-1:0]      busy,
   input  logic                  valid,
   input  logic [NSRC*REG_W-1:0] src,
   input  logic [NSRC-1:0]       src_use,
   input  logic                  has_dst,
   input  logic [REG_W-1:0]      dst,
   output logic                  ready
);
   logic [NSRC-1:0] src_hit;

   for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
      assign src_hit[gi] = src_use[gi] & busy[src[gi*REG_W +: REG_W]];
   end

   assign ready = valid & ~(|src_hit) & ~(has_dst & busy[dst]);
endmodule

// File: rtl/dip_pair_check.sv
module dip_pair_check
   import dip_pkg::*;
#(
   parameter int REG_W = 6,
   parameter int NSRC  = 2
) (
   input  iclass_e               old_cls,
   input  logic                  old_has_dst,
   input  logic [REG_W-1:0]      old_dst,
   input  iclass_e               yng_cls,
   input  logic [NSRC*REG_W-1:0] yng_src,
   input  logic [NSRC-1:0]       yng_src_use,
   input  logic                  yng_has_dst,
   input  logic [REG_W-1:0]      yng_dst,
   output logic                  pair_ok
);
   logic [NSRC-1:0] raw_hit;
   logic            waw_hit;
   logic            class_mix;

   for (genvar gi = 0; gi < NSRC; gi++) begin : g_raw
      assign raw_hit[gi] = yng_src_use[gi] & old_has_dst &
                           (yng_src[gi*REG_W +: REG_W] == old_dst);
   end

   assign waw_hit   = old_has_dst & yng_has_dst & (old_dst == yng_dst);
   assign class_mix = (old_cls != yng_cls);
   assign pair_ok   = class_mix & ~(|raw_hit) & ~waw_hit;
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
   import dip_pkg::*;
#(
   parameter int REG_W    = 6,
   parameter int NSRC     = 2,
   parameter int WB_PORTS = 2,
   localparam int NREGS   = 1 << REG_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      s0_valid,
   input  logic                      s0_cls,
   input  logic [NSRC*REG_W-1:0]     s0_src,
   input  logic [NSRC-1:0]           s0_src_use,
   input  logic                      s0_has_dst,
   input  logic [REG_W-1:0]          s0_dst,
   input  logic                      s1_valid,
   input  logic                      s1_cls,
   input  logic [NSRC*REG_W-1:0]     s1_src,
   input  logic [NSRC-1:0]           s1_src_use,
   input  logic                      s1_has_dst,
   input  logic [REG_W-1:0]          s1_dst,
   input  logic [WB_PORTS-1:0]       wb_valid,
   input  logic [WB_PORTS*REG_W-1:0] wb_reg,
   output logic                      issue0,
   output logic                      issue1,
   output logic [1:0]                issue_cnt,
   output logic [1:0]                set_en,
   output logic [2*REG_W-1:0]        set_reg,
   output logic [NREGS-1:0]          busy_mask
);
   if (REG_W < 1 || REG_W > 10) begin : g_bad_regw
      $error("dual_issue_pair: REG_W out of range");
   end
   if (NSRC < 1 || NSRC > 4) begin : g_bad_nsrc
      $error("dual_issue_pair: NSRC out of range");
   end
   if (WB_PORTS < 1 || WB_PORTS > 8) begin : g_bad_wb
      $error("dual_issue_pair: WB_PORTS out of range");
   end

   logic    rdy0, rdy1, pair_ok;
   iclass_e cls0, cls1;

   assign cls0 = iclass_e'(s0_cls);
   assign cls1 = iclass_e'(s1_cls);

   dip_slot_hazard #(.REG_W(REG_W), .NSRC(NSRC)) u_haz0 (
      .busy(busy_mask), .valid(s0_valid), .src(s0_src), .src_use(s0_src_use),
      .has_dst(s0_has_dst), .dst(s0_dst), .ready(rdy0)
   );

   dip_slot_hazard #(.REG_W(REG_W), .NSRC(NSRC)) u_haz1 (
      .busy(busy_mask), .valid(s1_valid), .src(s1_src), .src_use(s1_src_use),
      .has_dst(s1_has_dst), .dst(s1_dst), .ready(rdy1)
   );

   dip_pair_check #(.REG_W(REG_W), .NSRC(NSRC)) u_pair (
      .old_cls(cls0), .old_has_dst(s0_has_dst), .old_dst(s0_dst),
      .yng_cls(cls1), .yng_src(s1_src), .yng_src_use(s1_src_use),
      .yng_has_dst(s1_has_dst), .yng_dst(s1_dst), .pair_ok(pair_ok)
   );

   assign issue0    = rdy0;
   assign issue1    = rdy0 & rdy1 & pair_ok;
   assign issue_cnt = {issue0 & issue1, issue0 ^ issue1};
   assign set_en    = {issue1 & s1_has_dst, issue0 & s0_has_dst};
   assign set_reg   = {s1_dst, s0_dst};

   dip_scoreboard #(.REG_W(REG_W), .WB_PORTS(WB_PORTS)) u_sb (
      .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_reg(set_reg),
      .wb_valid(wb_valid), .wb_reg(wb_reg), .busy(busy_mask)
   );
endmodule

// File: rtl/dip_checker.sv
module dip_checker #(
   parameter int REG_W  = 6,
   parameter int NSRC   = 2,
   localparam int NREGS = 1 << REG_W
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  s0_valid,
   input logic                  s0_cls,
   input logic                  s0_has_dst,
   input logic [REG_W-1:0]      s0_dst,
   input logic                  s1_cls,
   input logic [NSRC*REG_W-1:0] s1_src,
   input logic [NSRC-1:0]       s1_src_use,
   input logic                  issue0,
   input logic                  issue1,
   input logic [1:0]            issue_cnt,
   input logic [1:0]            set_en,
   input logic [2*REG_W-1:0]    set_reg,
   input logic [NREGS-1:0]      busy_mask
);
   // R1
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_cnt != 2'd3) && (!s0_valid -> !issue0));

   // R2
   in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue1 |-> issue0);

   // R3
   class_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue1 |-> (s0_cls != s1_cls));

   // R4
   dst_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue0 && s0_has_dst) |-> !busy_mask[s0_dst]);

   // R7
   set_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_en[0] |=> busy_mask[$past(set_reg[REG_W-1:0])]);

   for (genvar gi = 0; gi < NSRC; gi++) begin : g_raw
      // R5
      raw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (issue1 && s0_has_dst && s1_src_use[gi]) |->
         (s1_src[gi*REG_W +: REG_W] != s0_dst));
   end
endmodule

bind dual_issue_pair dip_checker #(.REG_W(REG_W), .NSRC(NSRC)) u_dip_chk (
   .clk(clk), .rst_n(rst_n), .s0_valid(s0_valid), .s0_cls(s0_cls),
   .s0_has_dst(s0_has_dst), .s0_dst(s0_dst), .s1_cls(s1_cls),
   .s1_src(s1_src), .s1_src_use(s1_src_use), .issue0(issue0),
   .issue1(issue1), .issue_cnt(issue_cnt), .set_en(set_en),
   .set_reg(set_reg), .busy_mask(busy_mask)
);

// File: tb/test_dual_issue_pair.sv
module test_dual_issue_pair;
   localparam int REG_W = 6;
   localparam int NSRC  = 2;
   localparam int WBP   = 2;
   localparam int NREGS = 1 << REG_W;

   typedef struct packed {
      logic             v;
      logic             cls;
      logic [REG_W-1:0] a;
      logic [REG_W-1:0] b;
      logic             ua;
      logic             ub;
      logic             hd;
      logic [REG_W-1:0] d;
   } ins_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic                  s0_valid, s0_cls, s0_has_dst, s1_valid, s1_cls, s1_has_dst;
   logic [NSRC*REG_W-1:0] s0_src, s1_src;
   logic [NSRC-1:0]       s0_src_use, s1_src_use;
   logic [REG_W-1:0]      s0_dst, s1_dst;
   logic [WBP-1:0]        wb_valid;
   logic [WBP*REG_W-1:0]  wb_reg;
   logic                  issue0, issue1;
   logic [1:0]            issue_cnt, set_en;
   logic [2*REG_W-1:0]    set_reg;
   logic [NREGS-1:0]      busy_mask;

   dual_issue_pair #(.REG_W(REG_W), .NSRC(NSRC), .WB_PORTS(WBP)) i_dual_issue_pair (
      .clk(clk), .rst_n(rst_n),
      .s0_valid(s0_valid), .s0_cls(s0_cls), .s0_src(s0_src), .s0_src_use(s0_src_use),
      .s0_has_dst(s0_has_dst), .s0_dst(s0_dst),
      .s1_valid(s1_valid), .s1_cls(s1_cls), .s1_src(s1_src), .s1_src_use(s1_src_use),
      .s1_has_dst(s1_has_dst), .s1_dst(s1_dst),
      .wb_valid(wb_valid), .wb_reg(wb_reg),
      .issue0(issue0), .issue1(issue1), .issue_cnt(issue_cnt),
      .set_en(set_en), .set_reg(set_reg), .busy_mask(busy_mask)
   );

   int checks = 0;
   int errors = 0;
   logic [NREGS-1:0] mbusy;
   int cd [NREGS];
   int force_wb = -1;
   ins_t q[$];

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit ready(input ins_t x, input logic [NREGS-1:0] bz);
      return x.v && !(x.ua && bz[x.a]) && !(x.ub && bz[x.b]) && !(x.hd && bz[x.d]);
   endfunction

   function automatic ins_t mk(input bit cls, input int a, input bit ua, input int b,
                               input bit ub, input bit hd, input int d);
      ins_t x;
      x.v = 1'b1; x.cls = cls;
      x.a = REG_W'(a); x.ua = ua; x.b = REG_W'(b); x.ub = ub;
      x.hd = hd; x.d = REG_W'(d);
      return x;
   endfunction

   function automatic ins_t gen();
      ins_t x;
      bit fp;
      fp = ($urandom_range(0, 1) == 1);
      if (fp) x = mk(1'b1, 32 + $urandom_range(0, 5), 1'b1, 32 + $urandom_range(0, 5),
                     $urandom_range(0, 1) == 1, 1'b1, 32 + $urandom_range(0, 5));
      else if ($urandom_range(0, 3) == 0)
         // floating-point load: integer class, writes an FP register
         x = mk(1'b0, $urandom_range(0, 5), 1'b1, 0, 1'b0, 1'b1, 32 + $urandom_range(0, 5));
      else x = mk(1'b0, $urandom_range(0, 5), 1'b1, $urandom_range(0, 5),
                  $urandom_range(0, 1) == 1, $urandom_range(0, 4) != 0, $urandom_range(0, 5));
      if ($urandom_range(0, 15) == 0) x.v = 1'b0;
      return x;
   endfunction

   task automatic step();
      ins_t i0, i1;
      logic [NREGS-1:0] bz2;
      logic [WBP-1:0] wv;
      logic [WBP*REG_W-1:0] wr;
      bit e0, e1;
      int ports, cnt;
      string tag;
      while (q.size() < 2) q.push_back(gen());
      i0 = q[0]; i1 = q[1];
      s0_valid = i0.v; s0_cls = i0.cls; s0_src = {i0.b, i0.a}; s0_src_use = {i0.ub, i0.ua};
      s0_has_dst = i0.hd; s0_dst = i0.d;
      s1_valid = i1.v; s1_cls = i1.cls; s1_src = {i1.b, i1.a}; s1_src_use = {i1.ub, i1.ua};
      s1_has_dst = i1.hd; s1_dst = i1.d;
      wv = '0; wr = '0; ports = 0;
      if (force_wb >= 0) begin
         wv[0] = 1'b1; wr[REG_W-1:0] = REG_W'(force_wb); ports = 1;
      end
      for (int r = 0; r < NREGS; r++) begin
         if (cd[r] == 1 && ports < WBP) begin
            wv[ports] = 1'b1; wr[ports*REG_W +: REG_W] = REG_W'(r);
            ports++; cd[r] = 0;
         end
      end
      wb_valid = wv; wb_reg = wr;
      #5;
      // serial reference: slot 1 judged after slot 0's effect
      e0 = ready(i0, mbusy);
      bz2 = mbusy;
      if (e0 && i0.hd) bz2[i0.d] = 1'b1;
      e1 = e0 && i1.v && (i0.cls != i1.cls) && ready(i1, bz2);
      if (!e0) tag = "R2";
      else if (!i1.v) tag = "R1";
      else if (i0.cls == i1.cls) tag = "R3";
      else if (i0.hd && ((i1.ua && i1.a == i0.d) || (i1.ub && i1.b == i0.d))) tag = "R5";
      else if (i0.hd && i1.hd && i0.d == i1.d) tag = "R6";
      else if (!ready(i1, mbusy)) tag = "R4";
      else tag = "R10";
      cnt = int'(e0) + int'(e1);
      chk(issue0 == e0, "R4 slot0 issue", issue0, e0);
      chk(issue1 == e1, {tag, " slot1 issue"}, issue1, e1);
      chk(issue_cnt == 2'(cnt), "R1 count", issue_cnt, cnt);
      chk(busy_mask == mbusy, "R7 R8 busy", busy_mask, mbusy);
      chk(set_en == {e1 && i1.hd, e0 && i0.hd}, "R7 set_en", set_en, {e1 && i1.hd, e0 && i0.hd});
      if (e0 && i0.hd) chk(set_reg[REG_W-1:0] == i0.d, "R7 set_reg0", set_reg[REG_W-1:0], i0.d);
      if (e1 && i1.hd) chk(set_reg[2*REG_W-1:REG_W] == i1.d, "R7 set_reg1",
                           set_reg[2*REG_W-1:REG_W], i1.d);
      // model update at the edge
      for (int p = 0; p < WBP; p++) if (wv[p]) mbusy[wr[p*REG_W +: REG_W]] = 1'b0;
      for (int r = 0; r < NREGS; r++) if (cd[r] > 1) cd[r]--;
      if (e0 && i0.hd) begin
         mbusy[i0.d] = 1'b1;
         cd[i0.d] = i0.cls ? 3 + $urandom_range(0, 2) : 1 + $urandom_range(0, 1);
      end
      if (e1 && i1.hd) begin
         mbusy[i1.d] = 1'b1;
         cd[i1.d] = i1.cls ? 3 + $urandom_range(0, 2) : 1 + $urandom_range(0, 1);
      end
      force_wb = -1;
      if (cnt > 0) for (int k = 0; k < cnt; k++) void'(q.pop_front());
      else if (!i0.v) void'(q.pop_front());
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      mbusy = '0;
      for (int r = 0; r < NREGS; r++) cd[r] = 0;
      s0_valid = 0; s0_cls = 0; s0_src = '0; s0_src_use = '0; s0_has_dst = 0; s0_dst = '0;
      s1_valid = 0; s1_cls = 0; s1_src = '0; s1_src_use = '0; s1_has_dst = 0; s1_dst = '0;
      wb_valid = '0; wb_reg = '0;
      repeat (3) @(negedge clk);
      chk(busy_mask == '0, "R9 reset busy", busy_mask, 0);
      chk(issue0 == 1'b0 && issue_cnt == 2'd0, "R1 invalid slots", issue_cnt, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_mask == '0, "R9 after release", busy_mask, 0);
      // R3 mixed pair: fp add f1 plus integer op
      q.push_back(mk(1, 34, 1, 35, 1, 1, 33));
      q.push_back(mk(0, 1, 1, 2, 1, 1, 3));
      force_wb = 33; // R8 same-cycle writeback and set: bit must stay set
      step();
      // R3 two integer ops
      q.push_back(mk(0, 4, 1, 5, 0, 1, 6));
      q.push_back(mk(0, 4, 1, 5, 0, 1, 7));
      step(); step();
      repeat (6) step();
      // R5 fp load (integer class) feeding fp op
      q.push_back(mk(0, 1, 1, 0, 0, 1, 40));
      q.push_back(mk(1, 40, 1, 41, 1, 1, 42));
      step(); repeat (8) step();
      // R6 both write one register
      q.push_back(mk(1, 44, 1, 45, 1, 1, 46));
      q.push_back(mk(0, 2, 1, 0, 0, 1, 46));
      step(); repeat (8) step();
      // R10 younger writes what older reads
      q.push_back(mk(1, 47, 1, 48, 1, 1, 49));
      q.push_back(mk(0, 2, 1, 0, 0, 1, 47));
      step(); repeat (8) step();
      for (int n = 0; n < 4000; n++) step();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule